// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block is a watchdog for a system that must prove it is alive at regular intervals. Software sets it up through a small byte-wide register port and then keeps writing a fixed key to a kick register. A counter advances on each pulse of a slow timer tick. If no valid kick arrives before the programmed timeout expires, the block raises a one-cycle reset request toward the system reset controller.

In window mode, the count is divided into two parts. First there is a closed part, and any kick that lands in it is treated as a fault. After it comes an open part, in which a kick is accepted. An early-warning flag rises a programmable number of ticks after the count starts. Software can use it as an interrupt to kick just in time.

Every length is chosen with a 4-bit power-of-two code. An always-on bit keeps the timer running until the next system reset. A busy flag marks the cycle in which a written setting is taken over.

Top module: `wdw_top`

## Requirements
- R1: After reset the registers read: control 0x00, configuration 0xBB, early-warning 0x0B, flags 0x00, status 0x00. The register addresses are:
  - control: 0x0
  - configuration: 0x1, with the timeout code in bits 3:0 and the window code in bits 7:4
  - early-warning offset: 0x2, bits 3:0
  - enable-clear: 0x4
  - enable-set: 0x5
  - flags: 0x6
  - status: 0x7
  - kick: 0x8
- R2: In the control register, bit 1 is enable, bit 2 is window mode and bit 7 is always-on. All other control bits read as zero whatever is written.
- R3: A code c selects a length of 2^BASE_LOG2 · 2^min(c,11) ticks. With window mode off, `rst_req` pulses for one cycle exactly timeout-length ticks after the count starts. The count starts on enable or on an accepted kick.
- R4: While the block is disabled, the counter stays at zero and `rst_req` stays low.
- R5: In window mode, the timeout falls after the window length plus the timeout length. A kick made while fewer than window-length ticks have elapsed makes `rst_req` pulse in the next cycle. A kick made at or after that point restarts the count.
- R6: Writing 0xA5 to the kick register while enabled restarts the count. Any other value makes `rst_req` pulse in the next cycle. Kick writes while disabled have no effect, and the kick register reads as zero.
- R7: The early-warning flag (flags bit 0) rises exactly early-warning-length ticks after the count starts. Writing 1 to bit 0 clears it, and writing 0 leaves it unchanged.
- R8: The interrupt enable is readable at bit 0 of both 0x4 and 0x5. Writing 1 to bit 0 of 0x5 sets it, and writing 1 to bit 0 of 0x4 clears it. Writing 0 to either register has no effect. `irq` equals flag AND enable.
- R9: Writing control with bit 7 set turns on both always-on and enable. From then until reset, writes cannot change these two bits, while window mode stays writable.
- R10: Status bit 7 reads 1 for the cycle after a write to control, configuration, early-warning or kick, and 0 otherwise.
- R11: The counter advances only in cycles where `tmr_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_tick | input | 1 | Timer tick enable; one count per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Early-warning interrupt |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with BASE_LOG2 = 1, so the shortest length is 2 ticks and the longest is 4096. This brings every timeout code within a short run, including the four reserved codes that saturate. It also covers every early-warning offset below the longest timeout and a grid of window and timeout pairs, all measured to the exact cycle. The smaller base also makes it cheap to place kicks one tick before and exactly at the end of the closed window.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
  parameter int unsigned CODE_TOP = 11;   // largest legal length code
  parameter logic [7:0]  KICK_KEY = 8'hA5;

  localparam logic [3:0] A_CTRL    = 4'h0;
  localparam logic [3:0] A_CFG     = 4'h1;
  localparam logic [3:0] A_EWARN   = 4'h2;
  localparam logic [3:0] A_IEN_CLR = 4'h4;
  localparam logic [3:0] A_IEN_SET = 4'h5;
  localparam logic [3:0] A_FLAGS   = 4'h6;
  localparam logic [3:0] A_STAT    = 4'h7;
  localparam logic [3:0] A_KICK    = 4'h8;

  typedef struct packed {
    logic aon;
    logic win;
    logic en;
  } ctl_t;

  // Tick count selected by a length code; reserved codes saturate.
  function automatic int unsigned span(input logic [3:0] code, input int unsigned base_log2);
    int unsigned c;
    c = (int'(code) > CODE_TOP) ? CODE_TOP : int'(code);
    return 32'd1 << (base_log2 + c);
  endfunction
endpackage

// File: rtl/wdw_regs.sv
module wdw_regs
  import wdw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       ew_hit,
  output ctl_t       ctl,
  output logic [3:0] tmo_code,
  output logic [3:0] win_code,
  output logic [3:0] ew_code,
  output logic       kick,
  output logic       key_ok,
  output logic       irq
);
  logic [7:0] cfg_q;
  logic [3:0] ew_q;
  logic       ien_q, flag_q, busy_q;

  logic wr_ctrl, wr_cfg, wr_ew, wr_kick;
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_cfg  = bus_wr && (bus_addr == A_CFG);
  assign wr_ew   = bus_wr && (bus_addr == A_EWARN);
  assign wr_kick = bus_wr && (bus_addr == A_KICK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl    <= '0;
      cfg_q  <= 8'hBB;
      ew_q   <= 4'hB;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= wr_ctrl || wr_cfg || wr_ew || wr_kick;
      if (wr_ctrl) begin
        ctl.win <= bus_wdata[2];
        if (!ctl.aon) begin
          ctl.aon <= bus_wdata[7];
          ctl.en  <= bus_wdata[1] | bus_wdata[7];
        end
      end
      if (wr_cfg) cfg_q <= bus_wdata;
      if (wr_ew)  ew_q  <= bus_wdata[3:0];
      if (bus_wr && bus_addr == A_IEN_SET && bus_wdata[0]) ien_q <= 1'b1;
      else if (bus_wr && bus_addr == A_IEN_CLR && bus_wdata[0]) ien_q <= 1'b0;
      if (ew_hit) flag_q <= 1'b1;
      else if (bus_wr && bus_addr == A_FLAGS && bus_wdata[0]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_CTRL:               bus_rdata = {ctl.aon, 4'b0000, ctl.win, ctl.en, 1'b0};
      A_CFG:                bus_rdata = cfg_q;
      A_EWARN:              bus_rdata = {4'b0000, ew_q};
      A_IEN_CLR, A_IEN_SET: bus_rdata = {7'b0, ien_q};
      A_FLAGS:              bus_rdata = {7'b0, flag_q};
      A_STAT:               bus_rdata = {busy_q, 7'b0};
      default:              bus_rdata = 8'h00;
    endcase
  end

  assign tmo_code = cfg_q[3:0];
  assign win_code = cfg_q[7:4];
  assign ew_code  = ew_q;
  assign kick     = wr_kick && ctl.en;
  assign key_ok   = (bus_wdata == KICK_KEY);
  assign irq      = flag_q & ien_q;

  AST_AON_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.aon |=> (ctl.aon && ctl.en)); // R9
  AST_FLAG_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(bus_wr && bus_addr == A_FLAGS && bus_wdata[0])); // R7
endmodule

// File: rtl/wdw_count.sv
module wdw_count
  import wdw_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       win_en,
  input  logic       tick,
  input  logic       kick,
  input  logic       key_ok,
  input  logic [3:0] tmo_code,
  input  logic [3:0] win_code,
  input  logic [3:0] ew_code,
  output logic       ew_hit,
  output logic       rst_req
);
  localparam int CNT_W  = BASE_LOG2 + CODE_TOP + 2;
  localparam int N_LEN  = 3;   // 0: timeout, 1: window, 2: early warning

  logic [3:0]       codes [N_LEN];
  logic [CNT_W-1:0] lens  [N_LEN];
  assign codes[0] = tmo_code;
  assign codes[1] = win_code;
  assign codes[2] = ew_code;

  for (genvar i = 0; i < N_LEN; i++) begin : g_len
    assign lens[i] = CNT_W'(span(codes[i], BASE_LOG2));
  end

  logic [CNT_W-1:0] cnt, cnt_nx, limit;
  logic             closed, fault;

  assign cnt_nx = cnt + 1'b1;
  assign limit  = win_en ? (lens[0] + lens[1]) : lens[0];
  assign closed = win_en && (cnt < lens[1]);
  assign fault  = !key_ok || closed;
  assign ew_hit = en && !kick && tick && (cnt_nx == lens[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (!en) begin
        cnt <= '0;
      end else if (kick) begin
        cnt     <= '0;
        rst_req <= fault;
      end else if (tick) begin
        if (cnt_nx >= limit) begin
          cnt     <= '0;
          rst_req <= 1'b1;
        end else begin
          cnt <= cnt_nx;
        end
      end
    end
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (cnt < limit)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0 && !rst_req)); // R4
  AST_CLOSED_KICK_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && win_en && cnt < lens[1]) |=> rst_req); // R5
  AST_GOOD_KICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && key_ok && !closed) |=> (cnt == '0 && !rst_req)); // R6
endmodule

// File: rtl/wdw_top.sv
module wdw_top
  import wdw_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tmr_tick,
  input  logic       bus_wr,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       rst_req
);
  ctl_t       ctl;
  logic [3:0] tmo_code, win_code, ew_code;
  logic       kick, key_ok, ew_hit;

  wdw_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .ew_hit   (ew_hit),
    .ctl      (ctl),
    .tmo_code (tmo_code),
    .win_code (win_code),
    .ew_code  (ew_code),
    .kick     (kick),
    .key_ok   (key_ok),
    .irq      (irq)
  );

  wdw_count #(.BASE_LOG2(BASE_LOG2)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctl.en),
    .win_en  (ctl.win),
    .tick    (tmr_tick),
    .kick    (kick),
    .key_ok  (key_ok),
    .tmo_code(tmo_code),
    .win_code(win_code),
    .ew_code (ew_code),
    .ew_hit  (ew_hit),
    .rst_req (rst_req)
  );

  AST_RST_ONLY_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(ctl.en)); // R4
endmodule

// File: tb/tb_wdw_top.sv
module tb_wdw_top;
  localparam int BL = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tmr_tick = 1'b1;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq, rst_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  wdw_top #(.BASE_LOG2(BL)) dut (
    .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rst_req(rst_req)
  );

  always #5 clk = ~clk;

  function automatic int len(input int c);
    return (1 << BL) << ((c > 11) ? 11 : c);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_evt(input bit use_irq, input int maxn, output int n);
    n = 0;
    while (!(use_irq ? irq : rst_req) && n < maxn) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int n;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(4'h0, d); check(d == 8'h00, "R1 ctrl", d, 8'h00);
    rd(4'h1, d); check(d == 8'hBB, "R1 cfg", d, 8'hBB);
    rd(4'h2, d); check(d == 8'h0B, "R1 ewarn", d, 8'h0B);
    rd(4'h6, d); check(d == 8'h00, "R1 flags", d, 0);
    rd(4'h7, d); check(d == 8'h00, "R1 status", d, 0);
    check(rst_req == 1'b0 && irq == 1'b0, "R1 outputs", rst_req, 0);

    // R2 reserved control bits
    wr(4'h0, 8'h79); rd(4'h0, d); check(d == 8'h00, "R2 reserved", d, 8'h00);
    wr(4'h0, 8'h06); rd(4'h0, d); check(d == 8'h06, "R2 en+win", d, 8'h06);
    wr(4'h0, 8'h00);

    // R10 busy
    wr(4'h1, 8'hB0); rd(4'h7, d); check(d == 8'h80, "R10 busy set", d, 8'h80);
    @(negedge clk); rd(4'h7, d); check(d == 8'h00, "R10 busy clear", d, 0);
    wr(4'h6, 8'h00); rd(4'h7, d); check(d == 8'h00, "R10 no busy on flags", d, 0);

    // R4 disabled: no reset request, kick ignored
    seen = 0;
    wr(4'h8, 8'h5A);
    repeat (20) begin if (rst_req) seen = 1; @(negedge clk); end
    check(!seen, "R4 idle quiet", seen, 0);
    rd(4'h8, d); check(d == 8'h00, "R6 kick reads zero", d, 0);

    // R3 sweep of every timeout code, window off
    for (int c = 0; c < 16; c++) begin
      wr(4'h1, {4'hB, 4'(c)});
      wr(4'h0, 8'h02);
      wait_evt(1'b0, 10000, n);
      check(n == len(c), $sformatf("R3 timeout code %0d", c), n, len(c));
      @(negedge clk);
      check(!rst_req, "R3 one-cycle pulse", rst_req, 0);
      wr(4'h0, 8'h00);
    end

    // R5 window grid
    for (int w = 0; w < 4; w++) begin
      for (int p = 0; p < 4; p++) begin
        wr(4'h1, {4'(w), 4'(p)});
        wr(4'h0, 8'h06);
        wait_evt(1'b0, 10000, n);
        check(n == len(w) + len(p), $sformatf("R5 window %0d/%0d", w, p), n, len(w) + len(p));
        wr(4'h0, 8'h00);
      end
    end
    wr(4'h1, 8'hF0); wr(4'h0, 8'h06);
    wait_evt(1'b0, 10000, n);
    check(n == len(11) + len(0), "R5 saturated window", n, len(11) + len(0));
    wr(4'h0, 8'h00);

    // R5 kick one tick before the window opens (W=4, T=2)
    wr(4'h1, 8'h10); wr(4'h0, 8'h06);
    repeat (len(1) - 1) @(negedge clk);
    wr(4'h8, 8'hA5);
    check(rst_req == 1'b1, "R5 closed kick", rst_req, 1);
    wr(4'h0, 8'h00);
    // R5 kick exactly at the opening
    wr(4'h0, 8'h06);
    repeat (len(1)) @(negedge clk);
    wr(4'h8, 8'hA5);
    check(rst_req == 1'b0, "R5 open kick accepted", rst_req, 0);
    wait_evt(1'b0, 10000, n);
    check(n == len(1) + len(0), "R5 restart after kick", n, len(1) + len(0));
    wr(4'h0, 8'h00);

    // R6 key handling in normal mode
    wr(4'h1, 8'hB3); wr(4'h0, 8'h02);
    repeat (10) @(negedge clk);
    wr(4'h8, 8'hA5);
    check(rst_req == 1'b0, "R6 good key", rst_req, 0);
    wait_evt(1'b0, 10000, n);
    check(n == len(3), "R6 restart", n, len(3));
    wr(4'h0, 8'h00); wr(4'h0, 8'h02);
    repeat (3) @(negedge clk);
    wr(4'h8, 8'h5A);
    check(rst_req == 1'b1, "R6 bad key", rst_req, 1);
    wr(4'h0, 8'h00);

    // R8 enable set/clear
    wr(4'h5, 8'hFE); rd(4'h5, d); check(d == 8'h00, "R8 set with 0", d, 0);
    wr(4'h5, 8'h01); rd(4'h4, d); check(d == 8'h01, "R8 set", d, 1);
    wr(4'h4, 8'h00); rd(4'h5, d); check(d == 8'h01, "R8 clear with 0", d, 1);

    // R7 early-warning sweep
    wr(4'h1, 8'hBB);
    for (int e = 0; e < 11; e++) begin
      wr(4'h2, 8'(e));
      wr(4'h6, 8'h01);
      check(!irq, "R7 irq low before start", irq, 0);
      wr(4'h0, 8'h02);
      wait_evt(1'b1, 10000, n);
      check(n == len(e), $sformatf("R7 ew code %0d", e), n, len(e));
      wr(4'h0, 8'h00);
    end
    rd(4'h6, d); check(d == 8'h01, "R7 flag set", d, 1);
    wr(4'h6, 8'h00); rd(4'h6, d); check(d == 8'h01, "R7 write 0 keeps", d, 1);
    wr(4'h4, 8'h01);
    check(irq == 1'b0, "R8 irq masked", irq, 0);
    wr(4'h5, 8'h01);
    check(irq == 1'b1, "R8 irq unmasked", irq, 1);
    wr(4'h6, 8'h01); rd(4'h6, d); check(d == 8'h00, "R7 write 1 clears", d, 0);
    check(irq == 1'b0, "R8 irq follows flag", irq, 0);

    // R11 tick gating
    wr(4'h1, 8'hB0);
    tmr_tick = 1'b0;
    wr(4'h0, 8'h02);
    seen = 0;
    repeat (50) begin if (rst_req) seen = 1; @(negedge clk); end
    check(!seen, "R11 no ticks no count", seen, 0);
    tmr_tick = 1'b1;
    wait_evt(1'b0, 100, n);
    check(n == len(0), "R11 resume", n, len(0));
    wr(4'h0, 8'h00);

    // R9 always-on lock
    wr(4'h0, 8'h80); rd(4'h0, d); check(d == 8'h82, "R9 aon forces en", d, 8'h82);
    wr(4'h0, 8'h00); rd(4'h0, d); check(d == 8'h82, "R9 locked", d, 8'h82);
    wr(4'h0, 8'h04); rd(4'h0, d); check(d == 8'h86, "R9 window writable", d, 8'h86);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(4'h0, d); check(d == 8'h00, "R1 R9 reset unlocks", d, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule